// File: doc/BRIEF.md
# Host Bus Mode Entry Controller

This block decides which host bus protocol a peripheral's shared bus port speaks. While the active-high reset input is held, it reads two configuration straps. The value they hold in the last clock of reset picks 8-bit ISA, 16-bit ISA or PCMCIA operation. After reset, the block tracks the ISA read and write strobes, each through a synchroniser of `SYNC_STAGES` flops.

A host switches the port to a 68000-style asynchronous bus with a handshake. It first drives both ISA strobes low together, which no legal ISA cycle does. That moves the block into a pending state. The block then waits for the data strobe to go idle and inspects the next access. If that access is a write, 68000 mode is confirmed. Anything else returns the port to 16-bit ISA. Once 68000 mode is confirmed, it holds until reset is asserted again.

Outside the block, the mode code is used by the bus cycle engines, and the pin-function select routes the shared pins. In 68000 mode the address-enable pin serves as address strobe, the read pin as data strobe and the write pin as the read/write line. The block brings these three signals out already synchronised.

Top module: `bus_mode_ctl`

## Requirements
- R1: With `romNPin` high and `en16NPin` low in the last clock of reset, the block leaves reset with `modeCode` 1 (ISA 16-bit) and `pinFunc` 0 (ISA pin use). During reset `modeCode` follows the straps.
- R2: With `romNPin` high and `en16NPin` high at reset end, `modeCode` is 0 (ISA 8-bit) and `pinFunc` is 0.
- R3: With `romNPin` low at reset end, `modeCode` is 2 (PCMCIA) and `pinFunc` is 1, whatever the value of `en16NPin`.
- R4: In ISA 16-bit mode, `iordNPin` and `iowrNPin` both low moves the block to `modeCode` 3 (68000 pending) with `pinFunc` 2 (68000 pin use). A read strobe alone does not.
- R5: In pending, the block waits until `iordNPin` (data strobe) has returned high. If the next low on `iordNPin` comes with `iowrNPin` low, `modeCode` becomes 4 (68000 active). While the data strobe stays high, a low `iowrNPin` alone changes nothing.
- R6: In pending, if the next access after the data strobe returns high is made with `iowrNPin` high, the block returns to `modeCode` 1 and `pinFunc` 0.
- R7: Once in mode 4, no strobe pattern changes the mode. Only asserting `rstHi` returns the block to strap-based selection.
- R8: In ISA 8-bit and PCMCIA modes, both strobes low has no effect on `modeCode`.
- R9: While `pinFunc` is 2, `m68AsN`, `m68DsN` and `m68RwN` carry the synchronised `aenPin`, `iordNPin` and `iowrNPin`. Otherwise all three are held high.
- R10: A strobe change reaches `modeCode` exactly `SYNC_STAGES`+1 rising clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstHi | input | 1 | Hard reset, active high; straps are read while it is high |
| romNPin | input | 1 | Strap: low selects PCMCIA |
| en16NPin | input | 1 | Strap: low selects 16-bit ISA, high 8-bit ISA |
| aenPin | input | 1 | ISA address enable / 68000 address strobe (active low) |
| iordNPin | input | 1 | ISA read strobe / 68000 data strobe (active low) |
| iowrNPin | input | 1 | ISA write strobe / 68000 read-not-write line |
| modeCode | output | 3 | 0 ISA8, 1 ISA16, 2 PCMCIA, 3 68000 pending, 4 68000 active |
| pinFunc | output | 2 | Shared pin use: 0 ISA, 1 PCMCIA, 2 68000 |
| m68AsN | output | 1 | Synchronised address strobe in 68000 pin use, else high |
| m68DsN | output | 1 | Synchronised data strobe in 68000 pin use, else high |
| m68RwN | output | 1 | Synchronised read/write line in 68000 pin use, else high |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default 2. This shows that the handshake and the exact arrival cycle of R10 follow the parameter and are not fixed at two flops. It covers the following cases:
- the full entry handshake, including a write line that goes low ahead of the data strobe;
- the fallback taken by a read;
- the sticky active state under further strobe traffic;
- a re-entry into reset;
- all three strap decodes, with the ignored request checked in the two modes that refuse it.

// File: rtl/bus_mode_pkg.sv
package bus_mode_pkg;
  localparam int MODE_W = 3;
  localparam int PIN_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ISA8     = 3'd0,
    MODE_ISA16    = 3'd1,
    MODE_PCMCIA   = 3'd2,
    MODE_M68_PEND = 3'd3,
    MODE_M68      = 3'd4
  } busMode_e;

  typedef enum logic [PIN_W-1:0] {
    PIN_ISA    = 2'd0,
    PIN_PCMCIA = 2'd1,
    PIN_M68    = 2'd2
  } pinFunc_e;

  // Strobe events handed from the datapath to the control
  typedef struct packed {
    logic bothLow;   // read and write strobes low together
    logic dsActive;  // read pin (data strobe) low
    logic rwLow;     // write pin (read/write line) low
  } strobeEvt_t;
endpackage

// File: rtl/bus_mode_sync.sv
module bus_mode_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rstHi,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (rstHi) pipe[g] <= '1;
        else       pipe[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (rstHi) pipe[g] <= '1;
        else       pipe[g] <= pipe[g-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/bus_mode_dp.sv
module bus_mode_dp
  import bus_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstHi,
  input  logic       aenPin,
  input  logic       iordNPin,
  input  logic       iowrNPin,
  input  busMode_e   mode,
  output strobeEvt_t evt,
  output pinFunc_e   pinFunc,
  output logic       m68AsN,
  output logic       m68DsN,
  output logic       m68RwN
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] rawPins;
  logic [NSIG-1:0] syncPins;
  logic aenS, iordS, iowrS;

  assign rawPins = {aenPin, iordNPin, iowrNPin};

  bus_mode_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSIG)) u_sync (
    .clk  (clk),
    .rstHi(rstHi),
    .din  (rawPins),
    .dout (syncPins)
  );

  assign {aenS, iordS, iowrS} = syncPins;

  always_comb begin
    evt.bothLow  = !iordS && !iowrS;
    evt.dsActive = !iordS;
    evt.rwLow    = !iowrS;
  end

  always_comb begin
    unique case (mode)
      MODE_PCMCIA:             pinFunc = PIN_PCMCIA;
      MODE_M68_PEND, MODE_M68: pinFunc = PIN_M68;
      default:                 pinFunc = PIN_ISA;
    endcase
  end

  assign m68AsN = (pinFunc == PIN_M68) ? aenS  : 1'b1;
  assign m68DsN = (pinFunc == PIN_M68) ? iordS : 1'b1;
  assign m68RwN = (pinFunc == PIN_M68) ? iowrS : 1'b1;
endmodule

// File: rtl/bus_mode_fsm.sv
module bus_mode_fsm
  import bus_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstHi,
  input  logic       romNPin,
  input  logic       en16NPin,
  input  strobeEvt_t evt,
  output busMode_e   mode
);
  typedef enum logic [2:0] {
    ST_ISA8, ST_ISA16, ST_PCMCIA, ST_HOLD, ST_WAIT, ST_M68
  } state_e;

  state_e state, stateNxt, strapState;

  always_comb begin
    if (!romNPin)      strapState = ST_PCMCIA;
    else if (en16NPin) strapState = ST_ISA8;
    else               strapState = ST_ISA16;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_ISA16: if (evt.bothLow)   stateNxt = ST_HOLD;
      ST_HOLD:  if (!evt.dsActive) stateNxt = ST_WAIT;
      ST_WAIT:  if (evt.dsActive)  stateNxt = evt.rwLow ? ST_M68 : ST_ISA16;
      default:  stateNxt = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rstHi) state <= strapState;
    else       state <= stateNxt;
  end

  always_comb begin
    unique case (state)
      ST_ISA8:          mode = MODE_ISA8;
      ST_PCMCIA:        mode = MODE_PCMCIA;
      ST_HOLD, ST_WAIT: mode = MODE_M68_PEND;
      ST_M68:           mode = MODE_M68;
      default:          mode = MODE_ISA16;
    endcase
  end
endmodule

// File: rtl/bus_mode_ctl.sv
module bus_mode_ctl
  import bus_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstHi,
  input  logic                romNPin,
  input  logic                en16NPin,
  input  logic                aenPin,
  input  logic                iordNPin,
  input  logic                iowrNPin,
  output logic [MODE_W-1:0]   modeCode,
  output logic [PIN_W-1:0]    pinFunc,
  output logic                m68AsN,
  output logic                m68DsN,
  output logic                m68RwN
);
  strobeEvt_t evt;
  busMode_e   mode;
  pinFunc_e   pinSel;

  bus_mode_fsm u_fsm (
    .clk     (clk),
    .rstHi   (rstHi),
    .romNPin (romNPin),
    .en16NPin(en16NPin),
    .evt     (evt),
    .mode    (mode)
  );

  bus_mode_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstHi   (rstHi),
    .aenPin  (aenPin),
    .iordNPin(iordNPin),
    .iowrNPin(iowrNPin),
    .mode    (mode),
    .evt     (evt),
    .pinFunc (pinSel),
    .m68AsN  (m68AsN),
    .m68DsN  (m68DsN),
    .m68RwN  (m68RwN)
  );

  assign modeCode = mode;
  assign pinFunc  = pinSel;
endmodule

// File: rtl/bus_mode_chk.sv
module bus_mode_chk (
  input logic       clk,
  input logic       rstHi,
  input logic [2:0] modeCode,
  input logic [1:0] pinFunc,
  input logic       m68AsN,
  input logic       m68DsN,
  input logic       m68RwN
);
  // R7: active 68000 mode holds until reset
  p_m68_sticky_r7: assert property (@(posedge clk) disable iff (rstHi)
    modeCode == 3'd4 |=> modeCode == 3'd4);

  // R4: pending is entered only from ISA 16-bit
  p_pend_entry_r4: assert property (@(posedge clk) disable iff (rstHi)
    (modeCode == 3'd3 && $past(modeCode) != 3'd3) |-> $past(modeCode) == 3'd1);

  // R5: active mode is reached only through pending
  p_m68_entry_r5: assert property (@(posedge clk) disable iff (rstHi)
    (modeCode == 3'd4 && $past(modeCode) != 3'd4) |-> $past(modeCode) == 3'd3);

  // R8: 8-bit ISA and PCMCIA never move outside reset
  p_strap_fixed_r8: assert property (@(posedge clk) disable iff (rstHi)
    (modeCode == 3'd0 || modeCode == 3'd2) |=> $stable(modeCode));

  // R9: 68000 strobe outputs idle unless the pins are in 68000 use
  p_idle_strobes_r9: assert property (@(posedge clk) disable iff (rstHi)
    pinFunc != 2'd2 |-> (m68AsN && m68DsN && m68RwN));

  // R6: leaving pending without confirmation lands in ISA 16-bit
  p_fallback_r6: assert property (@(posedge clk) disable iff (rstHi)
    ($past(modeCode) == 3'd3 && modeCode != 3'd3) |-> (modeCode == 3'd4 || modeCode == 3'd1));
endmodule

bind bus_mode_ctl bus_mode_chk u_chk (
  .clk     (clk),
  .rstHi   (rstHi),
  .modeCode(modeCode),
  .pinFunc (pinFunc),
  .m68AsN  (m68AsN),
  .m68DsN  (m68DsN),
  .m68RwN  (m68RwN)
);

// File: tb/bus_mode_ctl_bench.sv
module bus_mode_ctl_bench;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rstHi = 1'b1;
  logic romNPin = 1'b1, en16NPin = 1'b0;
  logic aenPin = 1'b1, iordNPin = 1'b1, iowrNPin = 1'b1;
  logic [2:0] modeCode;
  logic [1:0] pinFunc;
  logic m68AsN, m68DsN, m68RwN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int    mode;
    int    pin;
    bit    chkStb;
    logic [2:0] stb;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  bus_mode_ctl #(.SYNC_STAGES(S)) u_bus_mode_ctl (
    .clk(clk), .rstHi(rstHi), .romNPin(romNPin), .en16NPin(en16NPin),
    .aenPin(aenPin), .iordNPin(iordNPin), .iowrNPin(iowrNPin),
    .modeCode(modeCode), .pinFunc(pinFunc),
    .m68AsN(m68AsN), .m68DsN(m68DsN), .m68RwN(m68RwN)
  );

  // Monitor: pops expected items and compares away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (modeCode != e.mode[2:0] || pinFunc != e.pin[1:0]) begin
          errors++;
          $display("FAIL %s mode/pin actual %0d/%0d expected %0d/%0d",
                   e.tag, modeCode, pinFunc, e.mode, e.pin);
        end
        if (e.chkStb) begin
          checks++;
          if ({m68AsN, m68DsN, m68RwN} != e.stb) begin
            errors++;
            $display("FAIL %s strobes actual %b expected %b",
                     e.tag, {m68AsN, m68DsN, m68RwN}, e.stb);
          end
        end
      end
    end
  end

  task automatic expect_(int mode, int pin, bit chkStb, logic [2:0] stb, string tag);
    exp_t e;
    e.mode = mode; e.pin = pin; e.chkStb = chkStb; e.stb = stb; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pins(logic a, logic r, logic w);
    aenPin = a; iordNPin = r; iowrNPin = w;
  endtask

  task automatic doReset(logic rom, logic en16);
    pins(1, 1, 1);
    rstHi = 1; romNPin = rom; en16NPin = en16;
    cyc(S + 3);
    rstHi = 0;
    cyc(1);
  endtask

  initial begin
    int cnt = 0;
    while (!done && cnt < 100000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: during reset the mode follows the straps, strobes idle
    cyc(3);
    expect_(1, 0, 1, 3'b111, "R1 in reset");
    rstHi = 0;
    cyc(1);
    expect_(1, 0, 1, 3'b111, "R1 after reset");

    // R4: a read alone does not request the switch
    pins(0, 0, 1);
    cyc(S + 3);
    expect_(1, 0, 1, 3'b111, "R4 read only");
    pins(1, 1, 1);
    cyc(S + 3);

    // R10 / R4: exact arrival of the request
    pins(1, 0, 0);
    cyc(S);
    expect_(1, 0, 0, 3'b111, "R10 before arrival");
    cyc(1);
    expect_(3, 2, 1, 3'b100, "R10 R4 pending");

    // R5: release data strobe, then write line low alone changes nothing
    pins(1, 1, 1);
    cyc(S + 3);
    expect_(3, 2, 1, 3'b111, "R5 released");
    pins(0, 1, 0);
    cyc(S + 3);
    expect_(3, 2, 1, 3'b010, "R5 R9 rw early");
    pins(0, 0, 0);
    cyc(S + 1);
    expect_(4, 2, 1, 3'b000, "R5 R9 confirmed");

    // R7: strobe traffic does not leave active mode
    pins(1, 1, 1); cyc(S + 2);
    pins(0, 0, 1); cyc(S + 2);
    pins(1, 0, 0); cyc(S + 2);
    expect_(4, 2, 1, 3'b100, "R7 sticky");
    pins(1, 1, 1);
    cyc(S + 2);

    // R7: reset returns to strap selection
    doReset(1, 0);
    expect_(1, 0, 1, 3'b111, "R7 after reset");

    // R6: a read after the request falls back to ISA 16-bit
    pins(1, 0, 0); cyc(S + 2);
    expect_(3, 2, 0, 3'b111, "R6 pending");
    pins(1, 1, 1); cyc(S + 2);
    pins(0, 0, 1); cyc(S + 2);
    expect_(1, 0, 1, 3'b111, "R6 R9 fallback");
    pins(1, 1, 1); cyc(S + 2);

    // R2 / R8: 8-bit ISA ignores the request
    doReset(1, 1);
    expect_(0, 0, 1, 3'b111, "R2 isa8");
    pins(1, 0, 0); cyc(S + 3);
    expect_(0, 0, 1, 3'b111, "R8 isa8 ignores");

    // R3 / R8: PCMCIA ignores the request, for both en16 values
    doReset(0, 0);
    expect_(2, 1, 1, 3'b111, "R3 pcmcia en16 low");
    pins(1, 0, 0); cyc(S + 3);
    expect_(2, 1, 1, 3'b111, "R8 pcmcia ignores");
    doReset(0, 1);
    expect_(2, 1, 0, 3'b111, "R3 pcmcia en16 high");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule